// File: doc/BRIEF.md
# Character-Cell CRT Timing Generator

This block produces the raster timing for a text display made of character cells. It runs on the character clock. It keeps three counters: the character position within a scan line, the scan line within a character row, and the character row within a frame. From these counters it derives horizontal and vertical sync, a display-enable window and a running character address that a later fetch stage can use. After the last character row of each frame, the frame can be stretched by a programmable number of adjust scan lines. Each sync output has its own polarity select.

All geometry comes from plain configuration inputs, which normally hold register contents. The block has no data stream, so it has no valid/ready handshake. Every pin is a level-sensitive control or status signal. Configuration is meant to stay stable while the block runs. A new set of values takes effect cleanly when it is applied under reset. "Line start" below means the first character clock of a scan line, where the horizontal position is 0.

Top module: `crtc_timing`

## Requirements
- R1: The horizontal position runs 0..`h_total` and then wraps, so each scan line lasts `h_total`+1 character clocks. The active horizontal sync begins at position `h_sync_pos`.
- R2: The horizontal sync stays active for the number of character clocks in `sync_widths[3:0]`, where 0 stands for 16. It ends early if the line wraps first.
- R3: Outside the adjust lines, `scan` counts 0..`scan_total` within each row, so a row has `scan_total`+1 scan lines. `scan` changes at line start.
- R4: `row` counts 0..`v_total` and moves forward at the line start that follows the last scan line of a row.
- R5: After the last scan line of row `v_total`, `v_adjust` extra lines follow before row 0 returns. 0 means none. During these lines `row` holds `v_total` and `scan` counts 0..`v_adjust`-1.
- R6: Vertical sync becomes active at the line start of scan line 0 of row `v_sync_pos`, outside the adjust lines. It stays active for the number of scan lines in `sync_widths[7:4]`, where 0 stands for 16. The count may continue across a frame boundary.
- R7: `disp_en` is high only when `de_begin` <= horizontal position < `de_end`, `row` < `v_disp` and the line is not an adjust line.
- R8: With `hsync_pol`/`vsync_pol` = 0 the matching sync output is active high. With 1 it is active low.
- R9: `char_addr` takes the row base at each line start and then increases by 1 every character clock, wrapping at 16 bits. The row base is `start_addr` at row 0 of each frame and increases by `h_disp` at every later row. Every scan line of a row restarts from the same base.
- R10: In reset, and in the first cycle after release, `row`, `scan` and `char_addr` are 0, `disp_en` follows the horizontal window at position 0, and vertical sync is inactive. The first frame uses row base 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_total | input | 8 | Last horizontal position of a line |
| h_disp | input | 8 | Characters per row, used as the row-base stride |
| h_sync_pos | input | 8 | Horizontal position where hsync starts |
| sync_widths | input | 8 | [7:4] vsync lines, [3:0] hsync clocks, 0 = 16 |
| v_total | input | 8 | Last character row of a frame |
| v_adjust | input | 5 | Adjust scan lines appended per frame |
| v_disp | input | 8 | Number of displayed rows |
| v_sync_pos | input | 8 | Row where vsync starts |
| scan_total | input | 5 | Last scan line index of a row |
| de_begin | input | 8 | First enabled horizontal position |
| de_end | input | 8 | First disabled horizontal position |
| hsync_pol | input | 1 | 1 makes hsync active low |
| vsync_pol | input | 1 | 1 makes vsync active low |
| start_addr | input | 16 | Row base for row 0 of each frame |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable |
| row | output | 8 | Current character row |
| scan | output | 5 | Current scan line within row or adjust block |
| char_addr | output | 16 | Character address counter |

## Verification
The bench goes after the coded width of zero. A design that treats it literally would give no sync pulse, or a one-cycle pulse, instead of 16. It also covers a zero adjust count, where an off-by-one design would insert an extra blank line or skip the frame wrap, and a vertical sync that runs on past the frame boundary, which a design that clears the sync count at frame top would cut short. Further cases are an empty enable window with begin after end, inverted polarities, and address reuse on every scan line of a row: a design that keeps counting across lines would show a wrong `char_addr` at the second scan line.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int SYNC_W = 4;

  // Coded sync width: a zero nibble means the maximum length 2**SYNC_W.
  function automatic logic [SYNC_W:0] sync_len(input logic [SYNC_W-1:0] n);
    sync_len = (n == '0) ? (SYNC_W+1)'(1 << SYNC_W) : {1'b0, n};
  endfunction
endpackage

// File: rtl/crtc_hcount.sv
module crtc_hcount
  import crtc_pkg::*;
#(
  parameter int H_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [H_W-1:0]      h_total,
  input  logic [H_W-1:0]      h_sync_pos,
  input  logic [SYNC_W-1:0]   hsw,
  input  logic [H_W-1:0]      de_begin,
  input  logic [H_W-1:0]      de_end,
  output logic                line_end,
  output logic                hsync_act,
  output logic                h_win
);
  logic [H_W-1:0] hc;
  logic [H_W:0]   hs_lo, hs_hi;

  assign line_end = (hc == h_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hc <= '0;
    else if (line_end) hc <= '0;
    else               hc <= hc + 1'b1;
  end

  always_comb begin
    hs_lo     = {1'b0, h_sync_pos};
    hs_hi     = hs_lo + (H_W+1)'(sync_len(hsw));
    hsync_act = ({1'b0, hc} >= hs_lo) && ({1'b0, hc} < hs_hi);
    h_win     = (hc >= de_begin) && (hc < de_end);
  end

  // R1: position only steps by one or restarts at zero
  p_hpos_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hc != '0) |-> (hc == $past(hc) + 1'b1));
  // R1: sync never rises away from its programmed start
  p_hsync_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_act) |-> (hc == h_sync_pos));
  // R2: sync ends at the coded width or at the line wrap
  p_hsync_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_act) |-> ((hc == '0) || ({1'b0, hc} == hs_hi)));
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount
  import crtc_pkg::*;
#(
  parameter int R_W = 8,
  parameter int S_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_end,
  input  logic [R_W-1:0]      v_total,
  input  logic [S_W-1:0]      v_adjust,
  input  logic [R_W-1:0]      v_disp,
  input  logic [R_W-1:0]      v_sync_pos,
  input  logic [S_W-1:0]      scan_total,
  input  logic [SYNC_W-1:0]   vsw,
  output logic [R_W-1:0]      row,
  output logic [S_W-1:0]      scan,
  output logic                in_adj,
  output logic                vsync_act,
  output logic                v_win,
  output logic                frame_next,
  output logic                row_next
);
  logic [R_W-1:0]  rc, n_rc;
  logic [S_W-1:0]  sl, n_sl;
  logic            adj, n_adj;
  logic [SYNC_W:0] vs_left;

  // Position of the following scan line, used at line end.
  always_comb begin
    n_rc       = rc;
    n_sl       = sl + 1'b1;
    n_adj      = adj;
    frame_next = 1'b0;
    row_next   = 1'b0;
    if (!adj) begin
      if (sl >= scan_total) begin
        n_sl = '0;
        if (rc == v_total) begin
          if (v_adjust == '0) begin
            n_rc       = '0;
            frame_next = 1'b1;
          end else begin
            n_adj = 1'b1;
          end
        end else begin
          n_rc     = rc + 1'b1;
          row_next = 1'b1;
        end
      end
    end else if ((sl + 1'b1) == v_adjust) begin
      n_sl       = '0;
      n_rc       = '0;
      n_adj      = 1'b0;
      frame_next = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc      <= '0;
      sl      <= '0;
      adj     <= 1'b0;
      vs_left <= '0;
    end else if (line_end) begin
      rc  <= n_rc;
      sl  <= n_sl;
      adj <= n_adj;
      if (!n_adj && (n_rc == v_sync_pos) && (n_sl == '0))
        vs_left <= sync_len(vsw);
      else if (vs_left != '0)
        vs_left <= vs_left - 1'b1;
    end
  end

  assign row       = rc;
  assign scan      = sl;
  assign in_adj    = adj;
  assign vsync_act = (vs_left != '0);
  assign v_win     = (rc < v_disp) && !adj;

  // R3: scan index stays inside the row outside adjust lines
  p_scan_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adj |-> (sl <= scan_total));
  // R4: scan index only changes at a line boundary
  p_scan_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_end) |-> (sl == $past(sl) && rc == $past(rc)));
  // R5: adjust lines sit after the last row and are bounded
  p_adj_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adj |-> (rc == v_total && sl < v_adjust));
  // R6: vertical sync starts only at scan 0 of the sync row
  p_vsync_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_act) |-> (sl == '0 && !adj && rc == v_sync_pos));
endmodule

// File: rtl/crtc_addr.sv
module crtc_addr #(
  parameter int A_W = 16,
  parameter int H_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_end,
  input  logic            frame_next,
  input  logic            row_next,
  input  logic [A_W-1:0]  start_addr,
  input  logic [H_W-1:0]  h_disp,
  output logic [A_W-1:0]  char_addr
);
  logic [A_W-1:0] base, ca, step_base;

  assign step_base = base + A_W'(h_disp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      ca   <= '0;
    end else if (line_end) begin
      if (frame_next) begin
        base <= start_addr;
        ca   <= start_addr;
      end else if (row_next) begin
        base <= step_base;
        ca   <= step_base;
      end else begin
        ca   <= base;
      end
    end else begin
      ca <= ca + 1'b1;
    end
  end

  assign char_addr = ca;

  // R9: within a line the address advances by exactly one
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> (ca == $past(ca) + 1'b1));
  // R9: each new frame restarts at the programmed start address
  p_addr_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && frame_next) |=> (ca == $past(start_addr)));
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int H_W = 8,
  parameter int R_W = 8,
  parameter int S_W = 5,
  parameter int A_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [H_W-1:0]        h_total,
  input  logic [H_W-1:0]        h_disp,
  input  logic [H_W-1:0]        h_sync_pos,
  input  logic [2*SYNC_W-1:0]   sync_widths,
  input  logic [R_W-1:0]        v_total,
  input  logic [S_W-1:0]        v_adjust,
  input  logic [R_W-1:0]        v_disp,
  input  logic [R_W-1:0]        v_sync_pos,
  input  logic [S_W-1:0]        scan_total,
  input  logic [H_W-1:0]        de_begin,
  input  logic [H_W-1:0]        de_end,
  input  logic                  hsync_pol,
  input  logic                  vsync_pol,
  input  logic [A_W-1:0]        start_addr,
  output logic                  hsync,
  output logic                  vsync,
  output logic                  disp_en,
  output logic [R_W-1:0]        row,
  output logic [S_W-1:0]        scan,
  output logic [A_W-1:0]        char_addr
);
  logic line_end, hsync_act, h_win;
  logic in_adj, vsync_act, v_win, frame_next, row_next;

  crtc_hcount #(.H_W(H_W)) u_h (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_total    (h_total),
    .h_sync_pos (h_sync_pos),
    .hsw        (sync_widths[SYNC_W-1:0]),
    .de_begin   (de_begin),
    .de_end     (de_end),
    .line_end   (line_end),
    .hsync_act  (hsync_act),
    .h_win      (h_win)
  );

  crtc_vcount #(.R_W(R_W), .S_W(S_W)) u_v (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end   (line_end),
    .v_total    (v_total),
    .v_adjust   (v_adjust),
    .v_disp     (v_disp),
    .v_sync_pos (v_sync_pos),
    .scan_total (scan_total),
    .vsw        (sync_widths[2*SYNC_W-1:SYNC_W]),
    .row        (row),
    .scan       (scan),
    .in_adj     (in_adj),
    .vsync_act  (vsync_act),
    .v_win      (v_win),
    .frame_next (frame_next),
    .row_next   (row_next)
  );

  crtc_addr #(.A_W(A_W), .H_W(H_W)) u_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end   (line_end),
    .frame_next (frame_next),
    .row_next   (row_next),
    .start_addr (start_addr),
    .h_disp     (h_disp),
    .char_addr  (char_addr)
  );

  assign hsync   = hsync_act ^ hsync_pol;
  assign vsync   = vsync_act ^ vsync_pol;
  assign disp_en = h_win & v_win;

  // R7: adjust lines are always blanked
  p_de_adjust_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_adj |-> !disp_en);
  // R7: no enable beyond the displayed rows
  p_de_rows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (row < v_disp));
  // R10: reset leaves the vertical counters at zero
  p_reset_state_r10: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (row == '0 && scan == '0)));
endmodule

// File: tb/crtc_timing_bench.sv
`timescale 1ns/1ps
module crtc_timing_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  h_total, h_disp, h_sync_pos, sync_widths, v_total, v_disp, v_sync_pos;
  logic [7:0]  de_begin, de_end;
  logic [4:0]  v_adjust, scan_total;
  logic        hsync_pol, vsync_pol;
  logic [15:0] start_addr;
  logic        hsync, vsync, disp_en;
  logic [7:0]  row;
  logic [4:0]  scan;
  logic [15:0] char_addr;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // reference model state
  int m_hc, m_sl, m_rc, m_vs, m_rb, m_ca;
  bit m_adj;

  always #2.5 clk = ~clk;

  crtc_timing u_crtc_timing (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .h_disp(h_disp),
    .h_sync_pos(h_sync_pos), .sync_widths(sync_widths), .v_total(v_total),
    .v_adjust(v_adjust), .v_disp(v_disp), .v_sync_pos(v_sync_pos),
    .scan_total(scan_total), .de_begin(de_begin), .de_end(de_end),
    .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .start_addr(start_addr),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .row(row),
    .scan(scan), .char_addr(char_addr)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      misses++;
      if (misses <= 25)
        $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int wlen(input int nib);
    return (nib == 0) ? 16 : nib;
  endfunction

  function automatic bit exp_hs();
    int lo = h_sync_pos;
    return (m_hc >= lo) && (m_hc < lo + wlen(sync_widths[3:0]));
  endfunction

  function automatic bit exp_de();
    return (m_hc >= de_begin) && (m_hc < de_end) && (m_rc < v_disp) && !m_adj;
  endfunction

  task automatic model_reset();
    m_hc = 0; m_sl = 0; m_rc = 0; m_vs = 0; m_rb = 0; m_ca = 0; m_adj = 0;
  endtask

  task automatic model_step();
    bit frame, newrow;
    if (m_hc != h_total) begin
      m_hc++;
      m_ca = (m_ca + 1) & 16'hFFFF;
    end else begin
      m_hc = 0; frame = 0; newrow = 0;
      if (!m_adj) begin
        if (m_sl == scan_total) begin
          m_sl = 0;
          if (m_rc == v_total) begin
            if (v_adjust == 0) begin m_rc = 0; frame = 1; end
            else m_adj = 1;
          end else begin m_rc++; newrow = 1; end
        end else m_sl++;
      end else begin
        if (m_sl + 1 == v_adjust) begin m_adj = 0; m_sl = 0; m_rc = 0; frame = 1; end
        else m_sl++;
      end
      if (!m_adj && m_rc == v_sync_pos && m_sl == 0) m_vs = wlen(sync_widths[7:4]);
      else if (m_vs > 0) m_vs--;
      if (frame) m_rb = start_addr;
      else if (newrow) m_rb = (m_rb + h_disp) & 16'hFFFF;
      m_ca = m_rb;
    end
  endtask

  task automatic compare_all();
    check((m_hc == h_sync_pos) ? "R1" : (hsync_pol ? "R8" : "R2"),
          hsync, exp_hs() ^ hsync_pol, "hsync");
    check(vsync_pol ? "R8" : "R6", vsync, (m_vs > 0) ^ vsync_pol, "vsync");
    check("R7", disp_en, exp_de(), "disp_en");
    check(m_adj ? "R5" : "R4", row, m_rc, "row");
    check(m_adj ? "R5" : "R3", scan, m_sl, "scan");
    check("R9", char_addr, m_ca, "char_addr");
  endtask

  task automatic run_cfg();
    int ncyc;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state visible while reset is held
    check("R10", row, 0, "row in reset");
    check("R10", scan, 0, "scan in reset");
    check("R10", char_addr, 0, "char_addr in reset");
    check("R10", vsync, vsync_pol, "vsync in reset");
    rst_n = 1'b1;
    model_reset();
    ncyc = (h_total + 1) * ((v_total + 1) * (scan_total + 1) + v_adjust) * 3 + 40;
    for (int i = 0; i < ncyc; i++) begin
      compare_all();
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic rand_cfg();
    h_total     = 8'(12 + $urandom_range(0, 28));
    h_disp      = 8'($urandom_range(1, h_total));
    h_sync_pos  = 8'($urandom_range(0, h_total));
    sync_widths = 8'($urandom_range(0, 255));
    v_total     = 8'($urandom_range(2, 7));
    v_disp      = 8'($urandom_range(0, v_total + 1));
    v_sync_pos  = 8'($urandom_range(0, v_total));
    scan_total  = 5'($urandom_range(0, 4));
    v_adjust    = 5'($urandom_range(0, 6));
    de_begin    = 8'($urandom_range(0, h_total + 2));
    de_end      = 8'($urandom_range(0, h_total + 2));
    hsync_pol   = 1'($urandom_range(0, 1));
    vsync_pol   = 1'($urandom_range(0, 1));
    start_addr  = 16'($urandom_range(0, 65535));
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // Directed: zero-coded widths mean 16 (R2, R6), no adjust lines (R5)
    h_total = 8'd39; h_disp = 8'd32; h_sync_pos = 8'd20; sync_widths = 8'h00;
    v_total = 8'd5; v_disp = 8'd4; v_sync_pos = 8'd1; scan_total = 5'd3;
    v_adjust = 5'd0; de_begin = 8'd2; de_end = 8'd34; hsync_pol = 0; vsync_pol = 0;
    start_addr = 16'hFFF0;
    run_cfg();
    // Directed: inverted polarity (R8), empty enable window (R7), adjust lines (R5),
    // vsync running past the frame boundary (R6)
    h_total = 8'd15; h_disp = 8'd10; h_sync_pos = 8'd0; sync_widths = 8'hF3;
    v_total = 8'd3; v_disp = 8'd4; v_sync_pos = 8'd3; scan_total = 5'd1;
    v_adjust = 5'd5; de_begin = 8'd9; de_end = 8'd4; hsync_pol = 1; vsync_pol = 1;
    start_addr = 16'h1234;
    run_cfg();
    // Directed: single-line rows, all rows displayed, one-line adjust
    h_total = 8'd20; h_disp = 8'd21; h_sync_pos = 8'd19; sync_widths = 8'h14;
    v_total = 8'd2; v_disp = 8'd9; v_sync_pos = 8'd0; scan_total = 5'd0;
    v_adjust = 5'd1; de_begin = 8'd0; de_end = 8'd21; hsync_pol = 0; vsync_pol = 1;
    start_addr = 16'h0100;
    run_cfg();
    for (int k = 0; k < 9; k++) begin
      rand_cfg();
      run_cfg();
    end
    done = 1;
    report();
  end
endmodule